// File: doc/BRIEF.md
# Programmable System Clock Divider Controller

This block produces the clock-enable strobe that paces a processor from a faster source clock. Software writes a control word. The word picks one of four normal division ratios: 1, 2, 4 or 8. A power-saving mode overrides that choice and divides by 256. The same word holds three more settings:

- an automatic switchback option,
- a stop request,
- regulator and oscillator controls.

The rest of the chip reads the strobe and the indications on the output ports.

When switchback is armed, a single-cycle wake request drops the block out of the divide-by-256 mode. The block then returns to the normal ratio with no software action. Stop mode freezes the strobe completely until a wake request arrives. On that wake request the divider restarts from zero with the ratio that was selected. Ratio changes never cut a period short: a new ratio is loaded only when the current period completes.

Top module: `sysclk_div_ctrl`

## Requirements
- R1: With the power-saving bit (control bit 2) at 0, the divide field (control bits 1:0) sets the period between `clk_en` pulses: code 0 gives 1 cycle, code 1 gives 2, code 2 gives 4 and code 3 gives 8. Each pulse is one cycle wide.
- R2: With control bit 2 at 1, `clk_en` pulses once every 256 cycles, whatever the divide field holds.
- R3: With switchback enabled (control bit 3 at 1), a `wake_req` cycle clears control bit 2 at the next clock edge. The cleared bit is visible on `ctrl_rd`.
- R4: A write that sets control bit 2 is ignored for that bit if it arrives in the same cycle as `wake_req` while switchback is enabled.
- R5: A new ratio is applied only after the pulse that ends the current period. The next period after that pulse uses the new ratio.
- R6: A write of 1 to the stop bit (control bit 4) sets `stopped` at the next edge. While `stopped` is 1, `clk_en` stays 0.
- R7: A `wake_req` while stopped clears the stop bit at the next edge. The divider then restarts from zero, so the first `clk_en` comes N cycles later for ratio N, and with ratio 1 it comes in the very next cycle.
- R8: `reg_keep_on` is 0 only while stopped with the regulator bit (control bit 5) at 0. Otherwise it is 1.
- R9: `osc_dis` follows the oscillator-disable bit (control bit 6) one edge after it is written.
- R10: After reset, `ctrl_rd` is 0, `stopped` is 0, `osc_dis` is 0 and `reg_keep_on` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 7 | Control word: [6] oscillator off, [5] regulator kept on in stop, [4] stop, [3] switchback enable, [2] divide-by-256, [1:0] divide code |
| wake_req | input | 1 | Single-cycle wake request (switchback and stop exit) |
| clk_en | output | 1 | System clock enable pulse |
| stopped | output | 1 | Stop mode indication |
| reg_keep_on | output | 1 | Regulator stays powered |
| osc_dis | output | 1 | High-frequency oscillator disabled |
| ctrl_rd | output | 7 | Read-back of the control word |

## Verification
The bench changes the divide code in the middle of a long period, and again right after a pulse. A design that reloads at once would give a short period, and the bench's model would catch the shifted pulse. Switchback is fired both during and outside the 256-cycle mode. The bench also writes the power-saving bit in the same cycle as a wake request. A design that honours the write would stay slow, and its read-back bit would still be 1. Stop is entered with the regulator bit at each of its two values, then left with a wake request under ratio 1 and ratio 8. A divider that resumed its old count instead of restarting would place the first pulse early.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
    localparam int DIV_SEL_W = 2;

    typedef struct packed {
        logic                 osc_off;
        logic                 reg_on;
        logic                 stop;
        logic                 sb_en;
        logic                 pm;
        logic [DIV_SEL_W-1:0] div_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sysclk_ctrl_reg.sv
module sysclk_ctrl_reg
    import sysclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  ctrl_t wr_word,
    input  logic  wake_req,
    output ctrl_t ctrl_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = wr_word;
        end
        // switchback: wake clears the power mode and blocks setting it
        if (ctrl_q.sb_en && wake_req) begin
            ctrl_d.pm = 1'b0;
        end
        // wake always leaves stop
        if (wake_req) begin
            ctrl_d.stop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end
endmodule

// File: rtl/sysclk_ratio_dec.sv
module sysclk_ratio_dec #(
    parameter int SEL_W   = 2,
    parameter int PM_LOG2 = 8,
    parameter int CNT_W   = 8
) (
    input  logic [SEL_W-1:0] div_sel,
    input  logic             pm,
    output logic [CNT_W-1:0] limit
);
    localparam int NSEL = 2 ** SEL_W;
    localparam logic [CNT_W-1:0] PM_LIMIT = CNT_W'((64'd1 << PM_LOG2) - 64'd1);

    logic [CNT_W-1:0] norm_tbl [NSEL];

    for (genvar i = 0; i < NSEL; i++) begin : g_tbl
        assign norm_tbl[i] = CNT_W'((64'd1 << i) - 64'd1);
    end

    always_comb begin
        if (pm) begin
            limit = PM_LIMIT;
        end else begin
            limit = norm_tbl[div_sel];
        end
    end
endmodule

// File: rtl/sysclk_div_cnt.sv
module sysclk_div_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic [CNT_W-1:0] lim_sel,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (halt) begin
            st_d.cnt = '0;
            st_d.lim = lim_sel;
        end else if (st_q.cnt == st_q.lim) begin
            tick     = 1'b1;
            st_d.cnt = '0;
            st_d.lim = lim_sel;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl
    import sysclk_pkg::*;
#(
    parameter int PM_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              wake_req,
    output logic              clk_en,
    output logic              stopped,
    output logic              reg_keep_on,
    output logic              osc_dis,
    output logic [CTRL_W-1:0] ctrl_rd
);
    localparam int NORM_MAX = 2 ** DIV_SEL_W - 1;
    localparam int CNT_W    = (PM_LOG2 > NORM_MAX) ? PM_LOG2 : NORM_MAX;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] lim_sel;

    sysclk_ctrl_reg i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_word  (ctrl_t'(wr_data)),
        .wake_req (wake_req),
        .ctrl_q   (ctrl_q)
    );

    sysclk_ratio_dec #(
        .SEL_W   (DIV_SEL_W),
        .PM_LOG2 (PM_LOG2),
        .CNT_W   (CNT_W)
    ) i_dec (
        .div_sel (ctrl_q.div_sel),
        .pm      (ctrl_q.pm),
        .limit   (lim_sel)
    );

    sysclk_div_cnt #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (ctrl_q.stop),
        .lim_sel (lim_sel),
        .tick    (clk_en)
    );

    assign stopped     = ctrl_q.stop;
    assign reg_keep_on = !(ctrl_q.stop && !ctrl_q.reg_on);
    assign osc_dis     = ctrl_q.osc_off;
    assign ctrl_rd     = ctrl_q;
endmodule

// File: rtl/sysclk_div_ctrl_chk.sv
module sysclk_div_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [6:0] wr_data,
    input logic       wake_req,
    input logic       clk_en,
    input logic       stopped,
    input logic       reg_keep_on,
    input logic       osc_dis,
    input logic [6:0] ctrl_rd
);
    p_stop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !clk_en);

    p_stop_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[4] && !wake_req) |=> stopped);

    p_sb_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[3] && wake_req) |=> !ctrl_rd[2]);

    p_wr_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2] && ctrl_rd[3] && wake_req) |=> !ctrl_rd[2]);

    p_wake_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && wake_req) |=> !stopped);

    p_restart_div1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && wake_req && !ctrl_rd[2] && ctrl_rd[1:0] == 2'd0) |=> clk_en);

    p_reg_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !ctrl_rd[5]) |-> !reg_keep_on);

    p_osc_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (osc_dis == $past(wr_data[6])));
endmodule

bind sysclk_div_ctrl sysclk_div_ctrl_chk i_chk (.*);

// File: tb/test_sysclk_div_ctrl.sv
module test_sysclk_div_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic       wake_req = 1'b0;
    logic       clk_en, stopped, reg_keep_on, osc_dis;
    logic [6:0] ctrl_rd;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    string tag      = "R1";

    // reference model state
    int m_sel, m_pm, m_sb, m_stop, m_reg, m_osc;
    int m_cnt, m_ratio;

    sysclk_div_ctrl i_sysclk_div_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wake_req(wake_req), .clk_en(clk_en), .stopped(stopped),
        .reg_keep_on(reg_keep_on), .osc_dis(osc_dis), .ctrl_rd(ctrl_rd)
    );

    always #5 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel = 0; m_pm = 0; m_sb = 0; m_stop = 0; m_reg = 0; m_osc = 0;
            m_cnt = 0; m_ratio = 1;
        end else begin
            int sel_ratio;
            sel_ratio = (m_pm != 0) ? 256 : (1 << m_sel);
            if (m_stop != 0) begin
                m_cnt = 0; m_ratio = sel_ratio;
            end else if (m_cnt == m_ratio - 1) begin
                m_cnt = 0; m_ratio = sel_ratio;
            end else begin
                m_cnt++;
            end
            begin
                int n_pm, n_stop;
                n_pm = m_pm; n_stop = m_stop;
                if (wr_en) begin
                    m_sel = wr_data[1:0]; n_pm = wr_data[2]; m_sb = wr_data[3];
                    n_stop = wr_data[4]; m_reg = wr_data[5]; m_osc = wr_data[6];
                end
                if (wake_req && m_sb_prev_ok()) n_pm = 0;
                if (wake_req) n_stop = 0;
                m_pm = n_pm; m_stop = n_stop;
            end
        end
    end

    // switchback arming is the value held before this edge's write
    logic sb_hold;
    always @(posedge clk or negedge rst_n)
        if (!rst_n) sb_hold <= 1'b0;
        else if (wr_en) sb_hold <= wr_data[3];
    function automatic bit m_sb_prev_ok();
        return sb_hold;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            check(tag, "clk_en", clk_en, (m_stop == 0 && m_cnt == m_ratio - 1) ? 1 : 0);
            check("R6", "stopped", stopped, m_stop);
            check(tag, "ctrl_rd", ctrl_rd,
                  (m_osc << 6) | (m_reg << 5) | (m_stop << 4) | (m_sb << 3) | (m_pm << 2) | m_sel);
            check("R8", "reg_keep_on", reg_keep_on, (m_stop != 0 && m_reg == 0) ? 0 : 1);
            check("R9", "osc_dis", osc_dis, m_osc);
            if (cycles > 150000) begin
                check("R1", "watchdog", 1, 0);
                finish_run();
            end
        end
    end

    task automatic write(logic [6:0] d, bit wake = 0);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wake_req = wake;
        @(negedge clk);
        wr_en = 1'b0; wake_req = 1'b0;
    endtask

    task automatic wake();
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1;
        check("R10", "reset ctrl_rd", ctrl_rd, 0);
        check("R10", "reset stopped", stopped, 0);
        check("R10", "reset osc_dis", osc_dis, 0);
        check("R10", "reset reg_keep_on", reg_keep_on, 1);
        #24 rst_n = 1'b1;

        tag = "R1";
        for (int s = 0; s < 4; s++) begin
            write(7'(s));
            run(40);
        end
        tag = "R5";
        write(7'd3); run(3); write(7'd1); run(20);
        write(7'd0); write(7'd2); run(20);
        tag = "R2";
        write(7'b0000110); run(300);
        write(7'b0000101); run(300);
        tag = "R5";
        write(7'b0000011); run(300);

        tag = "R3";
        write(7'b0001101); run(100); wake();
        check("R3", "pm cleared by switchback", ctrl_rd[2], 0);
        run(300);
        write(7'b0000100); wake();
        check("R3", "pm kept without switchback", ctrl_rd[2], 1);
        run(300);

        tag = "R4";
        write(7'b0001000); run(5);
        write(7'b0001100, 1);
        check("R4", "blocked pm write", ctrl_rd[2], 0);
        run(20);

        tag = "R6";
        write(7'b0010011); run(20);
        check("R6", "stop set", stopped, 1);
        check("R8", "regulator off in stop", reg_keep_on, 0);
        tag = "R7";
        wake(); run(30);
        tag = "R6";
        write(7'b0110000); run(10);
        check("R8", "regulator on in stop", reg_keep_on, 1);
        tag = "R7";
        @(negedge clk); wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        check("R7", "first pulse after wake at ratio 1", clk_en, 1);
        run(10);

        tag = "R9";
        write(7'b1000001); run(5);
        check("R9", "osc disabled", osc_dis, 1);
        write(7'b0000000); run(5);
        check("R9", "osc enabled", osc_dis, 0);

        finish_run();
    end
endmodule